// File: doc/BRIEF.md
# Sectored Four-Way Cache Tag Controller

This block keeps the tags and the per-sector state of a unified second-level cache. Each entry covers one 64-byte line split into two 32-byte sectors. Each sector has its own valid and modified bit. A lookup carries an address and a kind: instruction fetch, load or store. One cycle later the block returns hit or miss for the addressed sector. A hit also returns the sector index that locates the data. A miss is flagged for forwarding to the bus.

When the bus returns a sector, the fill path places it in one of four ways. It either joins a line whose tag is already resident, or it claims a new entry. For a new entry it takes a free unlocked way, or else follows a three-bit pseudo-LRU tree per set. If the evicted entry holds modified sectors, the block emits one castout per modified sector.

Configuration inputs cover the following:
- an enable, which takes effect only after a full invalidation;
- write-through stores;
- per-way locking;
- restricting allocation to data only or to instructions only.

A global invalidation clears one set per clock. While it runs, a busy flag is held high.

Top module: `l2tag_ctrl`

## Requirements
- R1: Out of reset, `inv_busy`, `rsp_valid`, `fl_done` and `co_valid` are 0 and `fill_ready` is 1. Until the first invalidation walk ends, the cache acts as disabled: lookups miss and fills do not allocate.
- R2: Address fields are as follows: bit 5 is the sector, bits [SET_W+5:6] are the set, and the remaining upper bits are the tag. A request sampled on one edge is answered on the next edge. The lookup hits only when a way holds the tag with that sector valid. `rsp_sidx` = {set, way, sector} on a hit. A miss raises `rsp_fwd`.
- R3: `inv_start` while idle raises `inv_busy` for exactly NUM_SETS cycles. This clears every valid bit, modified bit and tree state.
- R4: A lookup presented while `inv_busy` is high is answered with `rsp_reject`=1 and `rsp_hit`=`rsp_fwd`=0.
- R5: A fill marks its sector valid and clean. If the tag is already resident, the sector joins that way. Otherwise the lowest-numbered way that is both unlocked and fully invalid is used.
- R6: Tree bits per set are b0 (1 = victim among ways 2/3), b1 (way 0/1 pick) and b2 (way 2/3 pick). Every hit or fill to way w sets b0=~w[1] and sets the pick bit of w's pair to ~w[0]. With no free way, the victim follows the tree. A fully locked pair sends the choice to the other pair, and a locked leaf yields to its sibling.
- R7: `cfg_lock` bit i protects way i. With all four ways locked, a fill that needs a new entry reports `fl_alloc`=0 and issues no castout.
- R8: An evicted entry produces castouts only for its valid modified sectors, one per cycle, lower sector first. Each castout gives `co_addr` = {old tag, set, sector, 5'b0}. `fill_ready` is low until the last castout has been issued.
- R9: A store hit in copy-back mode sets the sector's modified bit and does not forward. With `cfg_wt`=1, a store hit forwards and leaves the bit clear.
- R10: Request kinds are encoded 0 = fetch, 1 = load, 2 = store (3 acts as load). `cfg_dataonly` blocks allocation by fetch fills. `cfg_instonly` blocks allocation by other fills.
- R11: A fill accepted in the same cycle as a lookup is performed, and that lookup is rejected.
- R12: With `cfg_enable`=0, lookups miss and forward, and fills do not allocate. Resident state is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Cache enable |
| cfg_wt | input | 1 | Write-through stores |
| cfg_lock | input | 4 | Per-way lock mask |
| cfg_dataonly | input | 1 | Allocate on data fills only |
| cfg_instonly | input | 1 | Allocate on fetch fills only |
| inv_start | input | 1 | Start global invalidation |
| inv_busy | output | 1 | Invalidation in progress |
| req_valid | input | 1 | Lookup request |
| req_type | input | 2 | Lookup kind |
| req_addr | input | ADDR_W | Lookup byte address |
| rsp_valid | output | 1 | Lookup answered |
| rsp_hit | output | 1 | Sector hit |
| rsp_fwd | output | 1 | Forward to bus |
| rsp_reject | output | 1 | Lookup not serviced |
| rsp_sidx | output | SET_W+3 | Sector index {set, way, sector} |
| fill_valid | input | 1 | Sector arriving from bus |
| fill_type | input | 2 | Kind of the original request |
| fill_addr | input | ADDR_W | Fill byte address |
| fill_ready | output | 1 | Fill can be taken |
| fl_done | output | 1 | Fill processed |
| fl_alloc | output | 1 | Fill placed in the array |
| fl_way | output | 2 | Way used by the fill |
| co_valid | output | 1 | Castout request |
| co_addr | output | ADDR_W | Castout sector address |

## Verification
A lookup and a fill share the single tag write port and can arrive on the same edge. The bench drives both on one cycle, with the lookup aimed at a line that is resident. It then expects the fill's completion and allocated way on the next cycle, together with a reject on the lookup. Follow-up lookups confirm that the filled line is now present and that the rejected line was left untouched. A second overlap occurs when a lookup arrives during an invalidation walk; that lookup must come back rejected, not missed.

// File: rtl/l2t_pkg.sv
package l2t_pkg;

  localparam int WAYS  = 4;
  localparam int OFF_W = 6;

  typedef enum logic [1:0] {
    RQ_IFETCH = 2'd0,
    RQ_LOAD   = 2'd1,
    RQ_STORE  = 2'd2,
    RQ_RSVD   = 2'd3
  } req_kind_e;

  // Point the tree away from the way just used.
  function automatic logic [2:0] plru_touch(input logic [2:0] bits, input logic [1:0] way);
    logic [2:0] r;
    r    = bits;
    r[0] = ~way[1];
    if (!way[1]) r[1] = ~way[0];
    else         r[2] = ~way[0];
    return r;
  endfunction

endpackage

// File: rtl/l2t_victim.sv
module l2t_victim
  import l2t_pkg::*;
(
  input  logic [2:0]      lru,
  input  logic [WAYS-1:0] lock,
  input  logic [WAYS-1:0] occ,
  output logic [1:0]      way,
  output logic            ok
);

  logic [WAYS-1:0] elig;
  logic [WAYS-1:0] free;
  logic            left_ok, right_ok, go_right, leaf;

  always_comb begin
    elig     = ~lock;
    free     = elig & ~occ;
    ok       = |elig;
    left_ok  = elig[0] | elig[1];
    right_ok = elig[2] | elig[3];
    go_right = lru[0] ? right_ok : !left_ok;
    leaf     = go_right ? lru[2] : lru[1];
    way      = '0;
    if (|free) begin
      for (int i = WAYS - 1; i >= 0; i--) begin
        if (free[i]) way = 2'(i);
      end
    end else begin
      way = {go_right, leaf};
      if (!elig[way]) way[0] = ~leaf;
    end
  end

endmodule

// File: rtl/l2t_inval.sv
module l2t_inval #(
  parameter int NUM_SETS = 256,
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             clr,
  output logic [SET_W-1:0] idx,
  output logic             done
);

  localparam logic [SET_W-1:0] LAST = SET_W'(NUM_SETS - 1);

  logic             busy_q, busy_d, done_q, done_d;
  logic [SET_W-1:0] idx_q, idx_d;

  always_comb begin
    busy_d = busy_q;
    done_d = done_q;
    idx_d  = idx_q;
    if (!busy_q && start) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q) begin
      if (idx_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      idx_q  <= idx_d;
    end
  end

  assign busy = busy_q;
  assign clr  = busy_q;
  assign idx  = idx_q;
  assign done = done_q;

endmodule

// File: rtl/l2t_castout.sv
module l2t_castout #(
  parameter int ADDR_W = 32,
  parameter int SET_W  = 8,
  parameter int OFF_W  = 6,
  localparam int TAG_W = ADDR_W - SET_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [SET_W-1:0]  ld_set,
  input  logic [1:0]        ld_mask,
  output logic              co_valid,
  output logic [ADDR_W-1:0] co_addr,
  output logic              busy
);

  logic [1:0]       mask_q, mask_d;
  logic [TAG_W-1:0] tag_q;
  logic [SET_W-1:0] set_q;
  logic             sec;

  assign sec      = !mask_q[0];
  assign co_valid = |mask_q;
  assign busy     = |mask_q;
  assign co_addr  = {tag_q, set_q, sec, {(OFF_W-1){1'b0}}};

  always_comb begin
    mask_d = mask_q;
    if (load)          mask_d = ld_mask;
    else if (co_valid) mask_d = mask_q & ~(2'b01 << sec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      tag_q <= ld_tag;
      set_q <= ld_set;
    end
  end

endmodule

// File: rtl/l2tag_ctrl.sv
module l2tag_ctrl
  import l2t_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_SETS = 256
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_enable,
  input  logic                          cfg_wt,
  input  logic [3:0]                    cfg_lock,
  input  logic                          cfg_dataonly,
  input  logic                          cfg_instonly,
  input  logic                          inv_start,
  output logic                          inv_busy,
  input  logic                          req_valid,
  input  logic [1:0]                    req_type,
  input  logic [ADDR_W-1:0]             req_addr,
  output logic                          rsp_valid,
  output logic                          rsp_hit,
  output logic                          rsp_fwd,
  output logic                          rsp_reject,
  output logic [$clog2(NUM_SETS)+2:0]   rsp_sidx,
  input  logic                          fill_valid,
  input  logic [1:0]                    fill_type,
  input  logic [ADDR_W-1:0]             fill_addr,
  output logic                          fill_ready,
  output logic                          fl_done,
  output logic                          fl_alloc,
  output logic [1:0]                    fl_way,
  output logic                          co_valid,
  output logic [ADDR_W-1:0]             co_addr
);

  localparam int SET_W  = $clog2(NUM_SETS);
  localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
  localparam int SIDX_W = SET_W + 3;

  // state arrays
  logic [TAG_W-1:0] tag_q [NUM_SETS][WAYS];
  logic [1:0]       vld_q [NUM_SETS][WAYS];
  logic [1:0]       mod_q [NUM_SETS][WAYS];
  logic [2:0]       lru_q [NUM_SETS];

  // invalidation walker
  logic             inv_clr, inv_done;
  logic [SET_W-1:0] inv_idx;

  l2t_inval #(.NUM_SETS(NUM_SETS)) inval_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (inv_start),
    .busy  (inv_busy),
    .clr   (inv_clr),
    .idx   (inv_idx),
    .done  (inv_done)
  );

  // address fields
  logic [SET_W-1:0] r_set, f_set;
  logic [TAG_W-1:0] r_tag, f_tag;
  logic             r_sec, f_sec;
  logic             unused_low;

  assign r_set = req_addr[OFF_W+SET_W-1:OFF_W];
  assign r_tag = req_addr[ADDR_W-1:OFF_W+SET_W];
  assign r_sec = req_addr[OFF_W-1];
  assign f_set = fill_addr[OFF_W+SET_W-1:OFF_W];
  assign f_tag = fill_addr[ADDR_W-1:OFF_W+SET_W];
  assign f_sec = fill_addr[OFF_W-1];
  assign unused_low = ^{req_addr[OFF_W-2:0], fill_addr[OFF_W-2:0]};

  // per-way compare
  logic [WAYS-1:0] r_match, f_tagm, f_occ;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign r_match[w] = (tag_q[r_set][w] == r_tag) && vld_q[r_set][w][r_sec];
    assign f_occ[w]   = |vld_q[f_set][w];
    assign f_tagm[w]  = (tag_q[f_set][w] == f_tag) && f_occ[w];
  end

  logic [1:0] r_hway, f_mway;

  always_comb begin
    r_hway = '0;
    f_mway = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (r_match[i]) r_hway = 2'(i);
      if (f_tagm[i])  f_mway = 2'(i);
    end
  end

  // victim choice
  logic [1:0] v_way;
  logic       v_ok;

  l2t_victim victim_i (
    .lru  (lru_q[f_set]),
    .lock (cfg_lock),
    .occ  (f_occ),
    .way  (v_way),
    .ok   (v_ok)
  );

  // castout sequencer
  logic       co_busy, co_load;
  logic [1:0] co_mask;

  l2t_castout #(.ADDR_W(ADDR_W), .SET_W(SET_W), .OFF_W(OFF_W)) castout_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (co_load),
    .ld_tag   (tag_q[f_set][v_way]),
    .ld_set   (f_set),
    .ld_mask  (co_mask),
    .co_valid (co_valid),
    .co_addr  (co_addr),
    .busy     (co_busy)
  );

  // control decode
  logic       eff_en, fill_take, type_ok, f_merge, f_alloc;
  logic [1:0] f_way, f_secbit, r_secbit;
  logic       req_rej, req_acc, r_hit, r_fwd, r_mark;

  assign fill_ready = !inv_busy && !co_busy;
  assign fill_take  = fill_valid && fill_ready;
  assign eff_en     = cfg_enable && inv_done;
  assign type_ok    = !(cfg_dataonly && (fill_type == RQ_IFETCH)) &&
                      !(cfg_instonly && (fill_type != RQ_IFETCH));
  assign f_merge    = |f_tagm;
  assign f_alloc    = fill_take && eff_en && type_ok && (f_merge || v_ok);
  assign f_way      = f_merge ? f_mway : v_way;
  assign f_secbit   = 2'b01 << f_sec;
  assign r_secbit   = 2'b01 << r_sec;
  assign co_load    = f_alloc && !f_merge;
  assign co_mask    = vld_q[f_set][v_way] & mod_q[f_set][v_way];

  assign req_rej = req_valid && (inv_busy || fill_take);
  assign req_acc = req_valid && !req_rej;
  assign r_hit   = req_acc && eff_en && (|r_match);
  assign r_fwd   = req_acc && (!r_hit || ((req_type == RQ_STORE) && cfg_wt));
  assign r_mark  = r_hit && (req_type == RQ_STORE) && !cfg_wt;

  // single write port into the arrays
  logic             wr_en, lru_we;
  logic [SET_W-1:0] wr_set, lru_set;
  logic [1:0]       wr_way, lru_way;
  logic [TAG_W-1:0] wr_tag;
  logic [1:0]       wr_vld, wr_mod;
  logic [2:0]       lru_nxt;

  always_comb begin
    wr_en   = 1'b0;
    wr_set  = f_set;
    wr_way  = f_way;
    wr_tag  = f_tag;
    wr_vld  = f_secbit;
    wr_mod  = '0;
    if (f_alloc) begin
      wr_en = 1'b1;
      if (f_merge) begin
        wr_vld = vld_q[f_set][f_way] | f_secbit;
        wr_mod = mod_q[f_set][f_way] & ~f_secbit;
      end
    end else if (r_mark) begin
      wr_en  = 1'b1;
      wr_set = r_set;
      wr_way = r_hway;
      wr_tag = r_tag;
      wr_vld = vld_q[r_set][r_hway];
      wr_mod = mod_q[r_set][r_hway] | r_secbit;
    end
    lru_we  = f_alloc || r_hit;
    lru_set = f_alloc ? f_set : r_set;
    lru_way = f_alloc ? f_way : r_hway;
    lru_nxt = plru_touch(lru_q[lru_set], lru_way);
  end

  always_ff @(posedge clk) begin
    if (inv_clr) begin
      for (int i = 0; i < WAYS; i++) begin
        vld_q[inv_idx][i] <= '0;
        mod_q[inv_idx][i] <= '0;
      end
      lru_q[inv_idx] <= '0;
    end else begin
      if (wr_en) begin
        tag_q[wr_set][wr_way] <= wr_tag;
        vld_q[wr_set][wr_way] <= wr_vld;
        mod_q[wr_set][wr_way] <= wr_mod;
      end
      if (lru_we) lru_q[lru_set] <= lru_nxt;
    end
  end

  // response registers
  logic              rsp_valid_d, rsp_hit_d, rsp_fwd_d, rsp_rej_d;
  logic [SIDX_W-1:0] rsp_sidx_d;
  logic              fl_done_d, fl_alloc_d;

  always_comb begin
    rsp_valid_d = req_valid;
    rsp_hit_d   = r_hit;
    rsp_fwd_d   = r_fwd;
    rsp_rej_d   = req_rej;
    rsp_sidx_d  = r_hit ? {r_set, r_hway, r_sec} : '0;
    fl_done_d   = fill_take;
    fl_alloc_d  = f_alloc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_fwd    <= 1'b0;
      rsp_reject <= 1'b0;
      rsp_sidx   <= '0;
      fl_done    <= 1'b0;
      fl_alloc   <= 1'b0;
      fl_way     <= '0;
    end else begin
      rsp_valid  <= rsp_valid_d;
      rsp_hit    <= rsp_hit_d;
      rsp_fwd    <= rsp_fwd_d;
      rsp_reject <= rsp_rej_d;
      if (req_valid) rsp_sidx <= rsp_sidx_d;
      fl_done    <= fl_done_d;
      fl_alloc   <= fl_alloc_d;
      if (fill_take) fl_way <= f_way;
    end
  end

endmodule

// File: rtl/l2tag_ctrl_chk.sv
module l2tag_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic inv_start,
  input logic inv_busy,
  input logic req_valid,
  input logic rsp_valid,
  input logic rsp_hit,
  input logic rsp_fwd,
  input logic rsp_reject,
  input logic fill_valid,
  input logic fill_ready,
  input logic fl_done,
  input logic fl_alloc,
  input logic co_valid
);

  a_r3_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inv_busy) |-> $past(inv_start));

  a_r4_reject_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && inv_busy) |=> (rsp_valid && rsp_reject && !rsp_hit && !rsp_fwd));

  a_r2_reject_excludes_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_reject |-> (!rsp_hit && !rsp_fwd));

  a_r8_castout_blocks_fill: assert property (@(posedge clk) disable iff (!rst_n)
    co_valid |-> !fill_ready);

  a_r11_fill_beats_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && fill_valid && fill_ready) |=> (rsp_reject && fl_done));

  a_r5_fill_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready) |=> fl_done);

  a_r7_alloc_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    fl_alloc |-> fl_done);

endmodule

bind l2tag_ctrl l2tag_ctrl_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .inv_start  (inv_start),
  .inv_busy   (inv_busy),
  .req_valid  (req_valid),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_fwd    (rsp_fwd),
  .rsp_reject (rsp_reject),
  .fill_valid (fill_valid),
  .fill_ready (fill_ready),
  .fl_done    (fl_done),
  .fl_alloc   (fl_alloc),
  .co_valid   (co_valid)
);

// File: tb/l2tag_ctrl_tb_top.sv
module l2tag_ctrl_tb_top;

  localparam int NS  = 16;
  localparam int SW  = 4;
  localparam int SXW = SW + 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cfg_enable, cfg_wt, cfg_dataonly, cfg_instonly, inv_start, inv_busy;
  logic [3:0] cfg_lock;
  logic req_valid, rsp_valid, rsp_hit, rsp_fwd, rsp_reject;
  logic [1:0] req_type, fill_type, fl_way;
  logic [31:0] req_addr, fill_addr, co_addr;
  logic [SXW-1:0] rsp_sidx;
  logic fill_valid, fill_ready, fl_done, fl_alloc, co_valid;

  l2tag_ctrl #(.ADDR_W(32), .NUM_SETS(NS)) dut_i (.*);

  int nvec = 0;
  int nfail = 0;
  bit finished = 0;

  function automatic logic [31:0] mk(input int t, input int s, input int sec);
    return 32'((t << 10) | (s << 6) | (sec << 5));
  endfunction

  // {fill, kind[1:0], addr[31:0], a, b, way[1:0]}
  function automatic logic [38:0] vec(input bit f, input logic [1:0] k, input int t,
                                      input int sec, input bit a, input bit b, input int w);
    return {f, k, mk(t, 1, sec), a, b, 2'(w)};
  endfunction

  localparam logic [38:0] VEC [0:14] = '{
    vec(0, 2'd1, 1, 0, 0, 1, 0), vec(1, 2'd1, 1, 0, 1, 0, 0),
    vec(0, 2'd1, 1, 0, 1, 0, 0), vec(0, 2'd1, 1, 1, 0, 1, 0),
    vec(1, 2'd1, 1, 1, 1, 0, 0), vec(0, 2'd1, 1, 1, 1, 0, 0),
    vec(1, 2'd1, 2, 0, 1, 0, 1), vec(1, 2'd1, 3, 0, 1, 0, 2),
    vec(1, 2'd1, 4, 0, 1, 0, 3), vec(0, 2'd2, 1, 0, 1, 0, 0),
    vec(0, 2'd2, 1, 1, 1, 0, 0), vec(1, 2'd1, 5, 0, 1, 0, 2),
    vec(0, 2'd1, 3, 0, 0, 1, 0), vec(0, 2'd1, 2, 0, 1, 0, 1),
    vec(1, 2'd1, 6, 0, 1, 0, 3)
  };

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic lookup(input logic [1:0] k, input logic [31:0] a,
                        output logic h, output logic f, output logic rj, output logic [SXW-1:0] sx);
    req_valid = 1'b1; req_type = k; req_addr = a;
    @(negedge clk);
    h = rsp_hit; f = rsp_fwd; rj = rsp_reject; sx = rsp_sidx;
    req_valid = 1'b0;
  endtask

  task automatic fill(input logic [1:0] k, input logic [31:0] a,
                      output logic al, output logic [1:0] w, output logic co);
    while (!fill_ready) @(negedge clk);
    fill_valid = 1'b1; fill_type = k; fill_addr = a;
    @(negedge clk);
    al = fl_alloc; w = fl_way; co = co_valid;
    fill_valid = 1'b0;
  endtask

  task automatic expect_lookup(input string rq, input logic [1:0] k, input logic [31:0] a,
                               input logic eh, input logic ef);
    logic h, f, rj;
    logic [SXW-1:0] sx;
    lookup(k, a, h, f, rj, sx);
    chk(rq, "hit", 64'(h), 64'(eh));
    chk(rq, "fwd", 64'(f), 64'(ef));
  endtask

  task automatic expect_fill(input string rq, input logic [1:0] k, input logic [31:0] a,
                             input logic ea, input logic [1:0] ew, input logic eco);
    logic al, co;
    logic [1:0] w;
    fill(k, a, al, w, co);
    chk(rq, "alloc", 64'(al), 64'(ea));
    if (ea) chk(rq, "way", 64'(w), 64'(ew));
    chk(rq, "castout", 64'(co), 64'(eco));
  endtask

  task automatic run_inval(output int cnt);
    inv_start = 1'b1;
    @(negedge clk);
    inv_start = 1'b0;
    cnt = 0;
    for (int i = 0; i < 4 * NS && inv_busy; i++) begin
      cnt++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic h, f, rj, al, co;
    logic [SXW-1:0] sx;
    logic [1:0] w;
    int cnt;
    rst_n = 1'b0; cfg_enable = 1'b1; cfg_wt = 1'b0; cfg_lock = '0;
    cfg_dataonly = 1'b0; cfg_instonly = 1'b0; inv_start = 1'b0;
    req_valid = 1'b0; req_type = '0; req_addr = '0;
    fill_valid = 1'b0; fill_type = '0; fill_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and behaviour before the first invalidation
    chk("R1", "inv_busy", 64'(inv_busy), 0);
    chk("R1", "rsp_valid", 64'(rsp_valid), 0);
    chk("R1", "fl_done", 64'(fl_done), 0);
    chk("R1", "co_valid", 64'(co_valid), 0);
    chk("R1", "fill_ready", 64'(fill_ready), 1);
    expect_fill("R1", 2'd1, mk(1, 1, 0), 1'b0, 2'd0, 1'b0);
    expect_lookup("R1", 2'd1, mk(1, 1, 0), 1'b0, 1'b1);

    // R3 walk length
    run_inval(cnt);
    chk("R3", "busy cycles", 64'(cnt), 64'(NS));

    // R2 R5 R6 R8 R9 vector table in set 1
    foreach (VEC[i]) begin
      logic [38:0] v;
      v = VEC[i];
      if (v[38]) begin
        fill(v[37:36], v[35:4], al, w, co);
        chk("R5/R6 table", "alloc", 64'(al), 64'(v[3]));
        chk("R5/R6 table", "way", 64'(w), 64'(v[1:0]));
        chk("R8 table", "castout", 64'(co), 64'(v[2]));
      end else begin
        lookup(v[37:36], v[35:4], h, f, rj, sx);
        chk("R2/R9 table", "hit", 64'(h), 64'(v[3]));
        chk("R2/R9 table", "fwd", 64'(f), 64'(v[2]));
        if (v[3]) chk("R2 table", "sidx", 64'(sx), 64'({4'd1, v[1:0], v[9]}));
      end
    end

    // R8 eviction of a twice-modified entry
    fill(2'd1, mk(7, 1, 1), al, w, co);
    chk("R8", "alloc way", 64'({al, w}), 64'({1'b1, 2'd0}));
    chk("R8", "first castout", 64'({co, co_addr}), 64'({1'b1, mk(1, 1, 0)}));
    chk("R8", "fill_ready low", 64'(fill_ready), 0);
    @(negedge clk);
    chk("R8", "second castout", 64'({co_valid, co_addr}), 64'({1'b1, mk(1, 1, 1)}));
    chk("R8", "fill_ready still low", 64'(fill_ready), 0);
    @(negedge clk);
    chk("R8", "castout done", 64'({co_valid, fill_ready}), 64'(2'b01));
    expect_lookup("R5", 2'd1, mk(7, 1, 1), 1'b1, 1'b0);
    expect_lookup("R5", 2'd1, mk(1, 1, 0), 1'b0, 1'b1);

    // R9 write-through in set 2
    cfg_wt = 1'b1;
    expect_fill("R9", 2'd1, mk(1, 2, 0), 1'b1, 2'd0, 1'b0);
    expect_lookup("R9", 2'd2, mk(1, 2, 0), 1'b1, 1'b1);
    expect_fill("R9", 2'd1, mk(2, 2, 0), 1'b1, 2'd1, 1'b0);
    expect_fill("R9", 2'd1, mk(3, 2, 0), 1'b1, 2'd2, 1'b0);
    expect_fill("R9", 2'd1, mk(4, 2, 0), 1'b1, 2'd3, 1'b0);
    expect_fill("R9", 2'd1, mk(5, 2, 0), 1'b1, 2'd0, 1'b0);
    cfg_wt = 1'b0;

    // R6 R7 locking in set 3
    cfg_lock = 4'b0011;
    expect_fill("R6", 2'd1, mk(1, 3, 0), 1'b1, 2'd2, 1'b0);
    expect_fill("R6", 2'd1, mk(3, 3, 0), 1'b1, 2'd3, 1'b0);
    expect_fill("R6", 2'd1, mk(4, 3, 0), 1'b1, 2'd2, 1'b0);
    cfg_lock = 4'b1111;
    expect_fill("R7", 2'd1, mk(2, 3, 0), 1'b0, 2'd0, 1'b0);
    expect_lookup("R7", 2'd1, mk(2, 3, 0), 1'b0, 1'b1);
    cfg_lock = 4'b0000;

    // R10 allocation filters
    cfg_dataonly = 1'b1;
    expect_fill("R10", 2'd0, mk(1, 4, 0), 1'b0, 2'd0, 1'b0);
    expect_lookup("R10", 2'd0, mk(1, 4, 0), 1'b0, 1'b1);
    expect_fill("R10", 2'd1, mk(1, 4, 0), 1'b1, 2'd0, 1'b0);
    cfg_dataonly = 1'b0; cfg_instonly = 1'b1;
    expect_fill("R10", 2'd1, mk(2, 5, 0), 1'b0, 2'd0, 1'b0);
    expect_fill("R10", 2'd0, mk(2, 5, 0), 1'b1, 2'd0, 1'b0);
    cfg_instonly = 1'b0;

    // R11 fill and lookup in one cycle
    req_valid = 1'b1; req_type = 2'd1; req_addr = mk(1, 4, 0);
    fill_valid = 1'b1; fill_type = 2'd1; fill_addr = mk(9, 6, 0);
    @(negedge clk);
    req_valid = 1'b0; fill_valid = 1'b0;
    chk("R11", "lookup rejected", 64'({rsp_reject, rsp_hit}), 64'(2'b10));
    chk("R11", "fill done", 64'({fl_done, fl_alloc, fl_way}), 64'(4'b1100));
    expect_lookup("R11", 2'd1, mk(9, 6, 0), 1'b1, 1'b0);
    expect_lookup("R11", 2'd1, mk(1, 4, 0), 1'b1, 1'b0);

    // R12 enable low
    cfg_enable = 1'b0;
    expect_lookup("R12", 2'd1, mk(1, 4, 0), 1'b0, 1'b1);
    expect_fill("R12", 2'd1, mk(10, 7, 0), 1'b0, 2'd0, 1'b0);
    cfg_enable = 1'b1;
    expect_lookup("R12", 2'd1, mk(1, 4, 0), 1'b1, 1'b0);
    expect_lookup("R12", 2'd1, mk(10, 7, 0), 1'b0, 1'b1);

    // R4 R3 lookup during a walk, then everything gone
    inv_start = 1'b1;
    @(negedge clk);
    inv_start = 1'b0;
    lookup(2'd1, mk(7, 1, 1), h, f, rj, sx);
    chk("R4", "reject/hit/fwd", 64'({rj, h, f}), 64'(3'b100));
    for (int i = 0; i < 4 * NS && inv_busy; i++) @(negedge clk);
    chk("R3", "busy dropped", 64'(inv_busy), 0);
    expect_lookup("R3", 2'd1, mk(7, 1, 1), 1'b0, 1'b1);
    expect_lookup("R3", 2'd1, mk(9, 6, 0), 1'b0, 1'b1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule